// File: doc/BRIEF.md
# Variable Register Shift Unit

This block performs a shift or rotate whose distance is taken from a second data operand rather than from an immediate field. It receives the decoded width bit, the flag-setting bit and the 6-bit function code of a two-source data-processing instruction, the value to be shifted and the distance operand. It returns the shifted value one clock later. Four kinds are available: logical left, logical right, arithmetic right and rotate right. Each kind works on either a 32-bit or a 64-bit datum.

The distance operand is reduced modulo the active width, so only its low 5 bits (32-bit mode) or low 6 bits (64-bit mode) matter. Any combination of the flag-setting bit and the function code that does not name one of the four shifts raises an unsupported flag. In that case the result is forced to zero. Register-file access, the zero-register rule, condition flags and program-counter update are handled elsewhere.

Top module: `vshift_unit`

## Requirements
- R1: `wide_i`=1 selects a 64-bit datum; `wide_i`=0 selects a 32-bit datum.
- R2: Only `setflg_i`=0 together with `func_i` 6'b001000, 6'b001001, 6'b001010 or 6'b001011 is supported. Every other combination sets `unsup_o`=1 and gives `res_o`=0. A supported one gives `unsup_o`=0.
- R3: Function code low bits 2'b00 shift left logically, filling with zeros.
- R4: Low bits 2'b01 shift right logically, filling with zeros from the top of the active width.
- R5: Low bits 2'b10 shift right arithmetically, filling with bit 31 (32-bit mode) or bit 63 (64-bit mode).
- R6: Low bits 2'b11 rotate right. Bits leaving position 0 re-enter at the top of the active width.
- R7: The effective distance is `amt_i` modulo the active width (bits 4:0 in 32-bit mode, bits 5:0 in 64-bit mode). Higher bits of `amt_i` have no effect.
- R8: In 32-bit mode, bits 63:32 of `opa_i` are ignored and bits 63:32 of `res_o` are zero.
- R9: An effective distance of zero returns the active-width operand unchanged for all four kinds.
- R10: Outputs update on the rising clock edge after the inputs are presented. A synchronous active-low reset clears `res_o` and `unsup_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_i | input | 1 | Width select: 1 = 64-bit, 0 = 32-bit |
| setflg_i | input | 1 | Flag-setting bit of the instruction |
| func_i | input | 6 | Function code |
| opa_i | input | 64 | Value to shift |
| amt_i | input | 64 | Shift-distance operand |
| res_o | output | 64 | Registered result |
| unsup_o | output | 1 | Registered unsupported-combination flag |

## Verification
The four kinds are driven with operands that have a set top bit and with operands whose top bit is clear. This separates arithmetic from logical right shift and shows where rotated bits wrap. Distances of 0, 1, width-1 and values above the width show whether the modulo reduction and the pass-through case are right. The 32-bit tests put non-zero data in the upper halves of both operands, so any leak of those bits into the result is visible. Random operands, widths and function codes, including unsupported ones, are compared every clock against a bit-by-bit model.

// File: rtl/vshift_pkg.sv
// Shared types for the variable shift unit.
package vshift_pkg;
    // Shift kind, taken from the two low function-code bits.
    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    // Upper four function-code bits shared by all supported shifts.
    localparam logic [3:0] SHIFT_GROUP = 4'b0010;
endpackage

// File: rtl/vshift_decode.sv
// Decoder: maps the flag-setting bit and the function code to a shift kind
// and an unsupported indication. Assumes nothing about the data operands.
module vshift_decode
    import vshift_pkg::*;
(
    input  logic        setflg,
    input  logic [5:0]  func,
    output shift_kind_e kind,
    output logic        unsup
);
    // Classify the instruction combination.
    always_comb begin
        kind  = shift_kind_e'(func[1:0]);
        unsup = setflg || (func[5:2] != SHIFT_GROUP);
    end
endmodule

// File: rtl/vshift_core.sv
// Combinational shifter. It builds one lane per width (half and full).
// The wide select picks a lane. The narrow lane zero-extends its result.
// Assumes DATA_W is even and a power of two.
module vshift_core
    import vshift_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] amt,
    input  shift_kind_e       kind,
    input  logic              wide,
    output logic [DATA_W-1:0] res
);
    localparam int HALF_W = DATA_W / 2;
    localparam int AMT_W  = $clog2(DATA_W);

    logic [DATA_W-1:0] lane_res [0:1];
    logic              unused_amt;

    assign unused_amt = ^amt[DATA_W-1:AMT_W];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        localparam int LW = (g == 1) ? DATA_W : HALF_W;
        localparam int LA = $clog2(LW);

        logic [LW-1:0]   x;
        logic [LA-1:0]   n;
        logic [2*LW-1:0] dbl;
        logic [LW-1:0]   r;

        assign x   = opa[LW-1:0];
        assign n   = amt[LA-1:0];
        assign dbl = {x, x} >> n;

        // Apply the selected shift kind within this lane width.
        always_comb begin
            unique case (kind)
                SK_LSL:  r = x << n;
                SK_LSR:  r = x >> n;
                SK_ASR:  r = $unsigned($signed(x) >>> n);
                default: r = dbl[LW-1:0];
            endcase
        end

        if (LW == DATA_W) begin : g_full
            assign lane_res[g] = r;
        end else begin : g_part
            assign lane_res[g] = {{(DATA_W-LW){1'b0}}, r};
        end
    end

    assign res = wide ? lane_res[1] : lane_res[0];
endmodule

// File: rtl/vshift_unit.sv
// Top of the variable shift unit: decode, shift, then one output register.
// Assumes inputs are stable around the rising edge. Synchronous active-low reset.
module vshift_unit
    import vshift_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_i,
    input  logic              setflg_i,
    input  logic [5:0]        func_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] amt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              unsup_o
);
    localparam int HALF_W = DATA_W / 2;
    localparam int AMT_W  = $clog2(DATA_W);

    shift_kind_e       kind;
    logic              unsup;
    logic [DATA_W-1:0] core_res;

    vshift_decode i_dec (
        .setflg (setflg_i),
        .func   (func_i),
        .kind   (kind),
        .unsup  (unsup)
    );

    vshift_core #(.DATA_W(DATA_W)) i_core (
        .opa  (opa_i),
        .amt  (amt_i),
        .kind (kind),
        .wide (wide_i),
        .res  (core_res)
    );

    // Register the result, or zero when the combination is unsupported.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_o   <= '0;
            unsup_o <= 1'b0;
        end else begin
            res_o   <= unsup ? '0 : core_res;
            unsup_o <= unsup;
        end
    end

    // R2
    unsup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> (res_o == '0));

    // R2
    unsup_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setflg_i || func_i[5:2] != SHIFT_GROUP) |=> unsup_o);

    // R8
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |=> (res_o[DATA_W-1:HALF_W] == '0));

    // R9
    zero_amt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_i && !setflg_i && func_i[5:2] == SHIFT_GROUP && amt_i[AMT_W-1:0] == '0)
        |=> (res_o == $past(opa_i)));

    // R6
    rotate_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_i && !setflg_i && func_i == {SHIFT_GROUP, 2'b11})
        |=> ($countones(res_o) == $countones($past(opa_i))));
endmodule

// File: tb/test_vshift_unit.sv
module test_vshift_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wide_i, setflg_i;
    logic [5:0]  func_i;
    logic [63:0] opa_i, amt_i;
    logic [63:0] res_o;
    logic        unsup_o;

    int tests = 0;
    int fails = 0;

    logic [63:0] exp_res;
    logic        exp_unsup;
    string       exp_tag;
    bit          pending = 1'b0;

    always #10 clk = ~clk;

    vshift_unit i_vshift_unit (
        .clk(clk), .rst_n(rst_n), .wide_i(wide_i), .setflg_i(setflg_i),
        .func_i(func_i), .opa_i(opa_i), .amt_i(amt_i),
        .res_o(res_o), .unsup_o(unsup_o)
    );

    function automatic bit model_unsup(bit s, logic [5:0] f);
        return s || (f[5:2] != 4'b0010);
    endfunction

    // Bit-by-bit behavioural reference.
    function automatic logic [63:0] model(bit w, bit s, logic [5:0] f,
                                          logic [63:0] a, logic [63:0] b);
        int wd = w ? 64 : 32;
        int n  = int'(b % 64'(wd));
        logic [63:0] r = '0;
        if (model_unsup(s, f)) return '0;
        for (int i = 0; i < wd; i++) begin
            case (f[1:0])
                2'd0: r[i] = (i >= n) ? a[i-n] : 1'b0;
                2'd1: r[i] = (i + n < wd) ? a[i+n] : 1'b0;
                2'd2: r[i] = (i + n < wd) ? a[i+n] : a[wd-1];
                default: r[i] = a[(i+n) % wd];
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(bit w, bit s, logic [5:0] f, logic [63:0] b);
        if (model_unsup(s, f)) return "R2";
        if (b % (w ? 64 : 32) == 0) return "R9";
        if (!w) return "R8";
        case (f[1:0])
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic compare();
        tests++;
        if (res_o !== exp_res || unsup_o !== exp_unsup) begin
            fails++;
            $display("FAIL %s: res=%h unsup=%b expected res=%h unsup=%b",
                     exp_tag, res_o, unsup_o, exp_res, exp_unsup);
        end
    endtask

    // Drive one vector at a falling edge. The result of the previous vector
    // is checked there, one rising edge after it was presented (R10).
    task automatic step(bit w, bit s, logic [5:0] f, logic [63:0] a,
                        logic [63:0] b, string tag);
        @(negedge clk);
        if (pending) compare();
        wide_i = w; setflg_i = s; func_i = f; opa_i = a; amt_i = b;
        exp_res   = model(w, s, f, a, b);
        exp_unsup = model_unsup(s, f);
        exp_tag   = (tag == "") ? tag_of(w, s, f, b) : tag;
        pending   = 1'b1;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        wide_i = 1'b1; setflg_i = 1'b0; func_i = 6'b001011;
        opa_i = 64'hFFFF_0000_1234_5678; amt_i = 64'd4;
        repeat (3) @(negedge clk);
        tests++;
        if (res_o !== 64'd0 || unsup_o !== 1'b0) begin
            fails++;
            $display("FAIL R10: reset res=%h unsup=%b expected res=0 unsup=0", res_o, unsup_o);
        end
        rst_n = 1'b1;

        // R3 R4 R5 R6 in 64-bit mode with negative operand
        step(1, 0, 6'b001000, 64'h8000_0000_0000_0081, 64'd1,  "R3");
        step(1, 0, 6'b001001, 64'h8000_0000_0000_0000, 64'd63, "R4");
        step(1, 0, 6'b001010, 64'h8000_0000_0000_0000, 64'd63, "R5");
        step(1, 0, 6'b001010, 64'h4000_0000_0000_0000, 64'd62, "R5");
        step(1, 0, 6'b001011, 64'h0000_0000_0000_0001, 64'd1,  "R6");
        // R1 R8: 32-bit mode with upper halves full of ones
        step(0, 0, 6'b001010, 64'hFFFF_FFFF_8000_0000, 64'd4,  "R1");
        step(0, 0, 6'b001011, 64'hFFFF_FFFF_0000_0001, 64'd1,  "R6");
        step(0, 0, 6'b001000, 64'hFFFF_FFFF_FFFF_FFFF, 64'd31, "R8");
        step(0, 0, 6'b001001, 64'hAAAA_AAAA_FFFF_FFFF, 64'd16, "R8");
        // R7: distances beyond the width
        step(1, 0, 6'b001000, 64'h0000_0000_0000_0001, 64'd69, "R7");
        step(0, 0, 6'b001011, 64'h0000_0000_0000_00F0, 64'hFFFF_FFFF_FFFF_FFE4, "R7");
        // R9: zero effective distance for all kinds
        for (int k = 0; k < 4; k++) begin
            step(1, 0, {4'b0010, 2'(k)}, 64'hC3C3_5A5A_0F0F_9999, 64'd128, "R9");
            step(0, 0, {4'b0010, 2'(k)}, 64'hC3C3_5A5A_8F0F_9999, 64'd32,  "R9");
        end
        // R2: unsupported combinations
        step(1, 1, 6'b001000, 64'h1234, 64'd1, "R2");
        step(1, 0, 6'b001100, 64'h1234, 64'd1, "R2");
        step(0, 0, 6'b000011, 64'h1234, 64'd1, "R2");

        // Random vectors, mostly supported codes
        for (int i = 0; i < 400; i++) begin
            logic [5:0] f;
            bit s;
            f = ($urandom_range(0, 7) == 0) ? 6'($urandom) : {4'b0010, 2'($urandom)};
            s = ($urandom_range(0, 9) == 0);
            step(1'($urandom), s, f, {$urandom, $urandom}, 64'($urandom_range(0, 200)), "");
        end
        @(negedge clk);
        compare();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule